// File: doc/BRIEF.md
# Error Interrupt Register Bank

This block gathers six single-cycle error pulses into sticky status bits and turns them into one level interrupt. Software reads the pending bits at one offset and writes ones there to acknowledge them. The enable mask is read-only at its own offset. It can only be changed through two strobe offsets: one unmasks the sources whose bits are written as one, and the other masks them again.

After reset every source is masked. Status bits still capture events while their source is masked. Unmasking a bit that is already pending therefore raises the interrupt without a fresh event. The interrupt output and the read data are both registered.

Source bit meanings: bit 0 is a manager-ID lookup miss, bit 1 a write by a manager whose ID entry allows reads only, bit 2 a read to an unmapped segment, bit 3 a write to an unmapped segment, bit 4 a manager not allowed in the segment it hit, bit 5 a non-secure access to a secure segment.

Top module: `irq_regbank`

## Requirements
- R1: Out of reset the status register reads 0x00, the mask register reads 0x3F, `irq` is 0 and `bus_rdata` is 0.
- R2: A high `err_evt[i]` at a clock edge sets status bit i, which then stays set whatever the mask holds; status is read at offset 0x10.
- R3: A write to 0x10 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Writes to the mask offset 0x14 have no effect on the mask.
- R6: Writing 1 to a bit at offset 0x18 clears that mask bit; bits written as 0 keep their mask value.
- R7: Writing 1 to a bit at offset 0x1C sets that mask bit; bits written as 0 keep their mask value.
- R8: Reads of 0x18 and 0x1C return zero.
- R9: `irq` goes high one clock after any status bit is 1 while its mask bit is 0, and otherwise goes low one clock after that condition clears.
- R10: Data bits above bit 5 read as zero and are ignored on writes; addresses other than the four offsets read zero and ignore writes.
- R11: `bus_rdata` shows the addressed register one clock after the cycle in which `bus_rd` is high, taken from the contents before that edge; it is zero after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| err_evt | input | 6 | Error event pulses, one per source |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that each write is a single-cycle strobe to one offset, so an enable and a disable never reach the mask together. Event inputs are treated as free-running, and the set-wins property allows for an event arriving in the same cycle as a clear. The stimulus drives writes and reads as separate one-cycle transactions on the falling edge. It raises events only in their own cycles, except in the single directed case where an event is deliberately overlapped with a clearing write.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_MASK   = 2'd2
  } rsel_e;

  localparam int SRC_ID_MISS   = 0;
  localparam int SRC_ID_RDONLY = 1;
  localparam int SRC_SEG_RMISS = 2;
  localparam int SRC_SEG_WMISS = 3;
  localparam int SRC_SEG_ID    = 4;
  localparam int SRC_SEG_SEC   = 5;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] stat_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             stat_q[g] <= 1'b0;
      else if (evt_i[g])   stat_q[g] <= 1'b1;
      else if (clr_i[g])   stat_q[g] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(clr_i & ~evt_i)) == '0)); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_i)) == '0)); // R2
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] dis_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= (mask_q & ~en_i) | dis_i;
  end

  assign mask_o = mask_q;

  AST_EN_UNMASKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((mask_q & $past(en_i & ~dis_i)) == '0)); // R6
  AST_DIS_MASKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~mask_q & $past(dis_i)) == '0)); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(en_i | dis_i)) == '0)); // R5
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_regbank_pkg::*;
#(
  parameter int                NUM_SRC  = 6,
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  rsel_e              sel;
  logic [NUM_SRC-1:0] field;
  logic [DATA_W-1:0]  rdata_q;

  always_comb begin
    if (!rd_i)                  sel = RSEL_NONE;
    else if (addr_i == OFS_STAT) sel = RSEL_STATUS;
    else if (addr_i == OFS_MASK) sel = RSEL_MASK;
    else                         sel = RSEL_NONE;
  end

  always_comb begin
    case (sel)
      RSEL_STATUS: field = stat_i;
      RSEL_MASK:   field = mask_i;
      default:     field = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= {{PAD_W{1'b0}}, field};
  end

  assign rdata_o = rdata_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_q == '0)); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata_q[DATA_W-1:NUM_SRC] == '0); // R10
  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == OFS_MASK) |=> (rdata_q[NUM_SRC-1:0] == $past(mask_i))); // R5
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int                NUM_SRC  = 6,
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_EN   = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_DIS  = 8'h1C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] err_evt,
  output logic               irq
);
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] stat_clr, mask_en, mask_dis;
  logic [NUM_SRC-1:0] stat_q, mask_q;
  logic               irq_q;
  logic               unused_wdata_hi;

  assign wbits           = bus_wdata[NUM_SRC-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

  assign stat_clr = (bus_wr && bus_addr == OFS_STAT) ? wbits : '0;
  assign mask_en  = (bus_wr && bus_addr == OFS_EN)   ? wbits : '0;
  assign mask_dis = (bus_wr && bus_addr == OFS_DIS)  ? wbits : '0;

  irq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (err_evt),
    .clr_i  (stat_clr),
    .stat_o (stat_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .en_i   (mask_en),
    .dis_i  (mask_dis),
    .mask_o (mask_q)
  );

  irq_read_port #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OFS_STAT (OFS_STAT),
    .OFS_MASK (OFS_MASK)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (bus_rd),
    .addr_i  (bus_addr),
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .rdata_o (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_q & ~mask_q);
  end

  assign irq = irq_q;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & ~mask_q)) |=> irq_q); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|(stat_q & ~mask_q))); // R9
  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd)); // R11
endmodule

// File: tb/sim_irq_regbank.sv
`timescale 1ns/1ps
module sim_irq_regbank;
  localparam int NUM_SRC = 6;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int LIMIT   = 20000;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_EVT = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{OP_RD,  8'h10, 32'h0000_0000, 8'd1},  // R1 status clear
    '{OP_RD,  8'h14, 32'h0000_003F, 8'd1},  // R1 all masked
    '{OP_IRQ, 8'h00, 32'h0000_0000, 8'd1},  // R1 irq low
    '{OP_EVT, 8'h00, 32'h0000_0005, 8'd2},  // R2 events 0 and 2
    '{OP_RD,  8'h10, 32'h0000_0005, 8'd2},  // R2 latched while masked
    '{OP_IRQ, 8'h00, 32'h0000_0000, 8'd9},  // R9 masked, no irq
    '{OP_WR,  8'h14, 32'h0000_0000, 8'd5},  // R5 direct mask write
    '{OP_RD,  8'h14, 32'h0000_003F, 8'd5},  // R5 unchanged
    '{OP_WR,  8'h18, 32'h0000_0004, 8'd6},  // R6 unmask bit 2
    '{OP_RD,  8'h14, 32'h0000_003B, 8'd6},  // R6 only bit 2 cleared
    '{OP_IRQ, 8'h00, 32'h0000_0001, 8'd9},  // R9 pending bit unmasked
    '{OP_WR,  8'h10, 32'h0000_0004, 8'd3},  // R3 clear bit 2
    '{OP_RD,  8'h10, 32'h0000_0001, 8'd3},  // R3 bit 0 kept
    '{OP_IRQ, 8'h00, 32'h0000_0000, 8'd9},  // R9 cause gone
    '{OP_RD,  8'h18, 32'h0000_0000, 8'd8},  // R8
    '{OP_RD,  8'h1C, 32'h0000_0000, 8'd8},  // R8
    '{OP_WR,  8'h18, 32'h0000_003F, 8'd6},  // R6 unmask all
    '{OP_RD,  8'h14, 32'h0000_0000, 8'd6},  // R6
    '{OP_IRQ, 8'h00, 32'h0000_0001, 8'd9},  // R9 bit 0 now enabled
    '{OP_WR,  8'h1C, 32'h0000_0031, 8'd7},  // R7 mask bits 0,4,5
    '{OP_RD,  8'h14, 32'h0000_0031, 8'd7},  // R7
    '{OP_IRQ, 8'h00, 32'h0000_0000, 8'd9},  // R9 masked again
    '{OP_WR,  8'h10, 32'hFFFF_FFC0, 8'd10}, // R10 upper bits only
    '{OP_RD,  8'h10, 32'h0000_0001, 8'd10}, // R10 status untouched
    '{OP_WR,  8'h20, 32'h0000_003F, 8'd10}, // R10 unmapped write
    '{OP_RD,  8'h14, 32'h0000_0031, 8'd10}, // R10 mask untouched
    '{OP_RD,  8'h20, 32'h0000_0000, 8'd10}, // R10 unmapped read
    '{OP_WR,  8'h10, 32'h0000_003F, 8'd3},  // R3 clear all
    '{OP_RD,  8'h10, 32'h0000_0000, 8'd3},  // R3
    '{OP_EVT, 8'h00, 32'h0000_0020, 8'd2},  // R2 masked source 5
    '{OP_RD,  8'h10, 32'h0000_0020, 8'd2},  // R2
    '{OP_IRQ, 8'h00, 32'h0000_0000, 8'd9},  // R9 masked
    '{OP_EVT, 8'h00, 32'h0000_0008, 8'd9},  // R9 enabled source 3
    '{OP_IRQ, 8'h00, 32'h0000_0001, 8'd9}   // R9 raised
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_SRC-1:0] err_evt = '0;
  logic              irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_regbank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .err_evt(err_evt), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_evt(input logic [NUM_SRC-1:0] v);
    err_evt = v;
    @(negedge clk);
    err_evt = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({31'd0, irq}, 32'd0, 1);   // R1
    check(bus_rdata, 32'd0, 1);      // R1

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR:  do_wr(TBL[i].addr, TBL[i].data);
        OP_RD:  begin do_rd(TBL[i].addr, rv); check(rv, TBL[i].data, int'(TBL[i].req)); end
        OP_EVT: do_evt(TBL[i].data[NUM_SRC-1:0]);
        default: begin @(negedge clk); check({31'd0, irq}, TBL[i].data, int'(TBL[i].req)); end
      endcase
    end

    // R11: no read in the previous cycle gives zero read data
    @(negedge clk);
    check(bus_rdata, 32'd0, 11);

    // R4: event and clear on the same bit in one cycle; status holds 0x28
    err_evt = 6'h02; bus_addr = 8'h10; bus_wdata = 32'h0000_0002; bus_wr = 1'b1;
    @(negedge clk);
    err_evt = '0; bus_wr = 1'b0; bus_wdata = '0;
    do_rd(8'h10, rv);
    check(rv, 32'h0000_002A, 4);

    // R11: read returns contents before the edge; event lands on same edge
    err_evt = 6'h01; bus_addr = 8'h10; bus_rd = 1'b1;
    @(negedge clk);
    err_evt = '0; bus_rd = 1'b0;
    check(bus_rdata, 32'h0000_002A, 11);
    do_rd(8'h10, rv);
    check(rv, 32'h0000_002B, 11);

    // R1: reset mid-run restores mask and clears irq/status
    do_wr(8'h18, 32'h0000_003F);
    @(negedge clk);
    check({31'd0, irq}, 32'd1, 9);   // R9
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({31'd0, irq}, 32'd0, 1);
    do_rd(8'h14, rv);
    check(rv, 32'h0000_003F, 1);
    do_rd(8'h10, rv);
    check(rv, 32'h0000_0000, 1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule